// File: doc/BRIEF.md
# Calendar-Time Counter with Alarm and Countdown Events

This block keeps wall-clock time for a chip in a single 32-bit word. The word holds four fields that carry into each other: seconds, minutes, hours and a day count. A time-base tick, normally a 32.768 kHz oscillator pulse that has already been brought into the block's clock domain, drives the counter. A prescaler can divide the tick down to one step per second, or it can pass every tick through as a step.

Every step can raise event flags. There is a flag for each step, and one each for a minute, hour and day rollover. A time-of-day alarm flag compares only the hours, minutes and seconds against a shared alarm word. A full alarm flag compares the whole word, day included. A countdown stopwatch raises its own flag when it runs out. The flags collect in a status register that software clears by writing ones. A control register of the same layout selects which flags drive the single interrupt output.

Registers are loaded through plain write strobes with their data. How those writes cross from a bus domain is handled outside the block.

Top module: `rtc_core`

## Requirements
- R1: After a synchronous active-low reset, the time word, alarm, stopwatch count, control and status registers are all zero and `irq` is low.
- R2: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. On each step, seconds advance. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one into the next field.
- R3: The day field wraps from 32767 to 0 when hours roll over.
- R4: With `presc_en` high, one step occurs on every `PRESCALE_DIV`-th tick, counted from the moment the prescaler was enabled. With `presc_en` low, every tick is a step.
- R5: Status bit 2 sets on every step. Bit 3 sets when seconds wrap to 0. Bit 4 sets when minutes and seconds both wrap. Bit 5 sets when the hour field rolls over into a new day.
- R6: Setting `stat_clr` clears every status bit whose `stat_clr_mask` bit is one, in the same cycle. Mask zeros leave their bits unchanged. An event arriving in the cycle of its own clear leaves the bit set.
- R7: Status bit 1 (time-of-day alarm) sets on a step whose new time matches the alarm word in bits 16:0. The day field is ignored.
- R8: Status bit 6 (full alarm) sets on a step whose new time equals the entire 32-bit alarm word.
- R9: A nonzero stopwatch count decrements by one on each step. The step that takes it from 1 to 0 sets status bit 0, and the count then holds at 0. A count of 0 raises no event. Writing a new count re-arms it.
- R10: `irq` is high exactly when some status bit is set whose control bit, at the same position, is also set.
- R11: A time write loads the word on the next clock edge and wins over a step in the same cycle. That step then changes no time field and raises no time event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle time-base pulse |
| presc_en | input | 1 | 1: divide ticks by PRESCALE_DIV; 0: pass every tick |
| time_wr | input | 1 | Load strobe for the time word |
| time_wdata | input | 32 | New packed time |
| alarm_wr | input | 1 | Load strobe for the alarm word |
| alarm_wdata | input | 32 | New packed alarm |
| swatch_wr | input | 1 | Load strobe for the stopwatch count |
| swatch_wdata | input | SW_W | New stopwatch count |
| ctrl_wr | input | 1 | Load strobe for the interrupt control mask |
| ctrl_wdata | input | 7 | New control mask |
| stat_clr | input | 1 | Write-one-to-clear strobe for status |
| stat_clr_mask | input | 7 | Bits to clear |
| time_q | output | 32 | Current packed time |
| alarm_q | output | 32 | Current alarm word |
| swatch_q | output | SW_W | Current stopwatch count |
| ctrl_q | output | 7 | Current control mask |
| status_q | output | 7 | Current event flags |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The bench walks the counter through more than an hour of consecutive steps from zero. It also sweeps across a day boundary and across the 32767-to-0 day wrap. Each new time and each flag is predicted from a running seconds total, so a field that wraps at 60 or 24 instead of 59 or 23, or a missing carry, shows up on the step where it happens.

The alarm is tested with a matching time of day on a different day. A design that compares the day field for the time-of-day alarm misses that event, and one that ignores the day for the full alarm fires it. The bench also checks a clear in the same cycle as a new event, a stopwatch that reaches zero and must hold there, a zero count that must stay silent, and a time write that collides with a step. A design that loses events, underflows the stopwatch or lets the step win is caught.

// File: rtl/rtc_core_pkg.sv
// Shared constants for the calendar-time counter: event bit positions and
// the layout of the packed time word.
package rtc_core_pkg;
    localparam int TIME_W  = 32;
    localparam int NUM_EV  = 7;

    // Event / control bit positions (software decodes these)
    localparam int EV_SWATCH   = 0;
    localparam int EV_TOD_ALM  = 1;
    localparam int EV_STEP     = 2;
    localparam int EV_MIN_ROLL = 3;
    localparam int EV_HR_ROLL  = 4;
    localparam int EV_DAY_ROLL = 5;
    localparam int EV_FULL_ALM = 6;

    // Sub-day fields, least significant first: seconds, minutes, hours
    localparam int NUM_SUBDAY = 3;
    localparam int FIELD_LSB [NUM_SUBDAY] = '{0, 6, 12};
    localparam int FIELD_W   [NUM_SUBDAY] = '{6, 6, 5};
    localparam int FIELD_MAX [NUM_SUBDAY] = '{59, 59, 23};

    localparam int DAY_LSB = 17;
    localparam int DAY_W   = TIME_W - DAY_LSB;
    localparam int TOD_W   = DAY_LSB;
endpackage

// File: rtl/rtc_prescaler.sv
// Time-base prescaler.
// Turns incoming oscillator ticks into counter steps. When enabled, one step
// is produced on every DIV-th tick. When disabled, the count is held at zero
// and every tick becomes a step.
// Assumes osc_tick is already synchronous to clk and lasts one cycle.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic en,
    output logic step
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step: the divided tick when enabled, the raw tick otherwise
    assign step = en ? (osc_tick && (cnt_q == LAST)) : osc_tick;

    // Tick counter: counts ticks while enabled, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (osc_tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_div_chk
            // R4
            presc_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && $past(en) && step) |=> !step);
        end
    endgenerate
endmodule

// File: rtl/rtc_time_counter.sv
// Packed time-word counter.
// Keeps seconds, minutes and hours in a carry chain, with a free-wrapping
// day field above them. A write loads the whole word and wins over a step
// in the same cycle. Exposes the post-step value and the carry outputs, so
// that the event logic can compare against the time being entered.
// Assumes software loads each field within its range. A field at or above
// its limit wraps on the next step.
module rtc_time_counter
    import rtc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr,
    input  logic [TIME_W-1:0] wdata,
    output logic [TIME_W-1:0] time_q,
    output logic [TIME_W-1:0] time_next,
    output logic              advance,
    output logic [NUM_SUBDAY-1:0] roll
);
    logic [NUM_SUBDAY:0] carry;

    assign advance  = step && !wr;
    assign carry[0] = advance;

    generate
        for (genvar g = 0; g < NUM_SUBDAY; g++) begin : g_field
            localparam int LSB = FIELD_LSB[g];
            localparam int W   = FIELD_W[g];
            localparam int MAX = FIELD_MAX[g];
            logic [W-1:0] cur;
            logic [W-1:0] nxt;
            logic         at_max;

            assign cur    = time_q[LSB +: W];
            assign at_max = (cur >= W'(MAX));
            assign carry[g+1] = carry[g] && at_max;

            // Field update: increment on incoming carry, wrap at the limit
            always_comb begin
                nxt = cur;
                if (carry[g])
                    nxt = at_max ? '0 : cur + 1'b1;
            end
            assign time_next[LSB +: W] = nxt;
        end
    endgenerate

    // Day field: wraps through its full width
    assign time_next[DAY_LSB +: DAY_W] = time_q[DAY_LSB +: DAY_W]
                                       + DAY_W'(carry[NUM_SUBDAY]);
    assign roll = carry[NUM_SUBDAY:1];

    // Time register: load wins, else take the advanced value
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_q <= '0;
        else if (wr)
            time_q <= wdata;
        else if (step)
            time_q <= time_next;
    end

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && time_q[5:0] == 6'd59) |=> (time_q[5:0] == 6'd0));
    // R3
    day_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && roll[NUM_SUBDAY-1]) |=>
        (time_q[TIME_W-1:DAY_LSB] == $past(time_q[TIME_W-1:DAY_LSB]) + 1'b1));
    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (time_q == $past(wdata)));
endmodule

// File: rtl/rtc_stopwatch.sv
// Countdown stopwatch.
// A nonzero count decrements once per step. The step that reaches zero
// raises a one-cycle done pulse, and the count then rests at zero. A count
// of zero is idle. A write reloads the count and suppresses that cycle's
// decrement.
module rtc_stopwatch #(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            wr,
    input  logic [SW_W-1:0] wdata,
    output logic [SW_W-1:0] cnt_q,
    output logic            done
);
    localparam logic [SW_W-1:0] ONE = SW_W'(1);

    logic dec;
    assign dec  = step && !wr && (cnt_q != '0);
    assign done = dec && (cnt_q == ONE);

    // Count register: reload on write, decrement while nonzero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr)
            cnt_q <= wdata;
        else if (dec)
            cnt_q <= cnt_q - 1'b1;
    end

    // R9
    sw_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R9
    sw_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_events.sv
// Event flags, alarm word and interrupt mask.
// Forms the seven event sources from the step, the carry outputs, the alarm
// compares and the stopwatch done pulse. Collects them in a sticky status
// register with write-one-to-clear, where a new event wins over its own
// clear. Drives the interrupt from the flags that the control mask enables.
module rtc_events
    import rtc_core_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance,
    input  logic [NUM_SUBDAY-1:0] roll,
    input  logic [TIME_W-1:0]     time_next,
    input  logic                  sw_done,
    input  logic                  alarm_wr,
    input  logic [TIME_W-1:0]     alarm_wdata,
    input  logic                  ctrl_wr,
    input  logic [NUM_EV-1:0]     ctrl_wdata,
    input  logic                  stat_clr,
    input  logic [NUM_EV-1:0]     stat_clr_mask,
    output logic [TIME_W-1:0]     alarm_q,
    output logic [NUM_EV-1:0]     ctrl_q,
    output logic [NUM_EV-1:0]     status_q,
    output logic                  irq
);
    logic [NUM_EV-1:0] ev;
    logic [NUM_EV-1:0] clr_bits;
    logic              tod_hit;
    logic              full_hit;

    assign tod_hit  = (time_next[TOD_W-1:0] == alarm_q[TOD_W-1:0]);
    assign full_hit = (time_next == alarm_q);

    // Event sources for this cycle
    always_comb begin
        ev              = '0;
        ev[EV_SWATCH]   = sw_done;
        ev[EV_TOD_ALM]  = advance && tod_hit;
        ev[EV_STEP]     = advance;
        ev[EV_MIN_ROLL] = advance && roll[0];
        ev[EV_HR_ROLL]  = advance && roll[1];
        ev[EV_DAY_ROLL] = advance && roll[2];
        ev[EV_FULL_ALM] = advance && full_hit;
    end

    assign clr_bits = stat_clr ? stat_clr_mask : '0;

    // Status register: clear requested bits, then set new events on top
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_bits) | ev;
    end

    // Alarm and control registers: plain loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (alarm_wr)
                alarm_q <= alarm_wdata;
            if (ctrl_wr)
                ctrl_q <= ctrl_wdata;
        end
    end

    // Interrupt: any enabled flag
    assign irq = |(status_q & ctrl_q);

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && ((stat_clr_mask & ev) == '0)) |=>
        ((status_q & $past(stat_clr_mask)) == '0));
    // R6
    event_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status_q & $past(ev)) == $past(ev)));
    // R8
    full_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && time_next == alarm_q) |=> status_q[EV_FULL_ALM]);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == '0) |-> !irq);
endmodule

// File: rtl/rtc_core.sv
// Calendar-time counter top.
// Joins the prescaler, the packed time counter, the countdown stopwatch and
// the event/interrupt logic. All loads are single-cycle strobes in the clk
// domain. Any crossing from a bus domain is done outside.
module rtc_core
    import rtc_core_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768,
    parameter int SW_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              presc_en,
    input  logic              time_wr,
    input  logic [31:0]       time_wdata,
    input  logic              alarm_wr,
    input  logic [31:0]       alarm_wdata,
    input  logic              swatch_wr,
    input  logic [SW_W-1:0]   swatch_wdata,
    input  logic              ctrl_wr,
    input  logic [6:0]        ctrl_wdata,
    input  logic              stat_clr,
    input  logic [6:0]        stat_clr_mask,
    output logic [31:0]       time_q,
    output logic [31:0]       alarm_q,
    output logic [SW_W-1:0]   swatch_q,
    output logic [6:0]        ctrl_q,
    output logic [6:0]        status_q,
    output logic              irq
);
    logic                  step;
    logic                  advance;
    logic [TIME_W-1:0]     time_next;
    logic [NUM_SUBDAY-1:0] roll;
    logic                  sw_done;

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .en       (presc_en),
        .step     (step)
    );

    rtc_time_counter u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .wr        (time_wr),
        .wdata     (time_wdata),
        .time_q    (time_q),
        .time_next (time_next),
        .advance   (advance),
        .roll      (roll)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_swatch (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wr    (swatch_wr),
        .wdata (swatch_wdata),
        .cnt_q (swatch_q),
        .done  (sw_done)
    );

    rtc_events u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .advance       (advance),
        .roll          (roll),
        .time_next     (time_next),
        .sw_done       (sw_done),
        .alarm_wr      (alarm_wr),
        .alarm_wdata   (alarm_wdata),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .stat_clr      (stat_clr),
        .stat_clr_mask (stat_clr_mask),
        .alarm_q       (alarm_q),
        .ctrl_q        (ctrl_q),
        .status_q      (status_q),
        .irq           (irq)
    );
endmodule

// File: tb/rtc_core_bench.sv
// Self-checking bench: predicts time, flags, stopwatch and interrupt from a
// running seconds total and compares after every stimulus.
module rtc_core_bench;
    localparam int DIV  = 4;
    localparam int SW_W = 8;
    localparam longint DAY_S  = 86400;
    localparam longint WRAP_S = 32768 * 86400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            osc_tick = 1'b0;
    logic            presc_en = 1'b0;
    logic            time_wr = 1'b0;
    logic [31:0]     time_wdata = '0;
    logic            alarm_wr = 1'b0;
    logic [31:0]     alarm_wdata = '0;
    logic            swatch_wr = 1'b0;
    logic [SW_W-1:0] swatch_wdata = '0;
    logic            ctrl_wr = 1'b0;
    logic [6:0]      ctrl_wdata = '0;
    logic            stat_clr = 1'b0;
    logic [6:0]      stat_clr_mask = '0;
    logic [31:0]     time_q;
    logic [31:0]     alarm_q;
    logic [SW_W-1:0] swatch_q;
    logic [6:0]      ctrl_q;
    logic [6:0]      status_q;
    logic            irq;

    int checks = 0;
    int errors = 0;

    // Model state
    longint      m_tot = 0;
    logic [31:0] m_alarm = '0;
    int          m_sw = 0;
    logic [6:0]  m_ctrl = '0;
    logic [6:0]  m_stat = '0;
    int          m_pcnt = 0;

    always #4 clk = ~clk;

    rtc_core #(.PRESCALE_DIV(DIV), .SW_W(SW_W)) u_rtc_core (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .presc_en(presc_en),
        .time_wr(time_wr), .time_wdata(time_wdata),
        .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata),
        .swatch_wr(swatch_wr), .swatch_wdata(swatch_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_clr(stat_clr), .stat_clr_mask(stat_clr_mask),
        .time_q(time_q), .alarm_q(alarm_q), .swatch_q(swatch_q),
        .ctrl_q(ctrl_q), .status_q(status_q), .irq(irq)
    );

    function automatic logic [31:0] pack(longint t);
        longint s = t % 60;
        longint m = (t / 60) % 60;
        longint h = (t / 3600) % 24;
        longint d = (t / DAY_S) % 32768;
        return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
    endfunction

    function automatic longint unpack(logic [31:0] v);
        return longint'(v[31:17]) * DAY_S + longint'(v[16:12]) * 3600
             + longint'(v[11:6]) * 60 + longint'(v[5:0]);
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, "time", time_q, pack(m_tot));
        chk(req, "status", 32'(status_q), 32'(m_stat));
        chk(req, "swatch", 32'(swatch_q), 32'(m_sw));
        chk(req, "irq", 32'(irq), 32'(|(m_stat & m_ctrl)));
    endtask

    // Model of one counter step (time advance and its events)
    task automatic model_advance(bit time_blocked);
        logic [31:0] nw;
        if (m_sw != 0) begin
            m_sw--;
            if (m_sw == 0) m_stat[0] = 1'b1;
        end
        if (time_blocked) return;
        m_tot = (m_tot + 1) % WRAP_S;
        nw = pack(m_tot);
        m_stat[2] = 1'b1;
        if (nw[5:0] == 0) m_stat[3] = 1'b1;
        if (nw[11:0] == 0) m_stat[4] = 1'b1;
        if (nw[16:0] == 0) m_stat[5] = 1'b1;
        if (nw[16:0] == m_alarm[16:0]) m_stat[1] = 1'b1;
        if (nw == m_alarm) m_stat[6] = 1'b1;
    endtask

    // One oscillator tick, optionally with a status clear in the same cycle
    task automatic tick_clr(logic [6:0] mask, string req);
        @(negedge clk);
        osc_tick = 1'b1;
        stat_clr = (mask != 0);
        stat_clr_mask = mask;
        @(negedge clk);
        osc_tick = 1'b0;
        stat_clr = 1'b0;
        stat_clr_mask = '0;
        m_stat &= ~mask;
        if (presc_en) begin
            m_pcnt++;
            if (m_pcnt == DIV) begin
                m_pcnt = 0;
                model_advance(1'b0);
            end
        end else begin
            model_advance(1'b0);
        end
        chk_all(req);
    endtask

    task automatic clr(logic [6:0] mask, string req);
        @(negedge clk);
        stat_clr = 1'b1;
        stat_clr_mask = mask;
        @(negedge clk);
        stat_clr = 1'b0;
        stat_clr_mask = '0;
        m_stat &= ~mask;
        chk_all(req);
    endtask

    task automatic set_time(logic [31:0] v, string req);
        @(negedge clk);
        time_wr = 1'b1;
        time_wdata = v;
        @(negedge clk);
        time_wr = 1'b0;
        m_tot = unpack(v);
        chk_all(req);
    endtask

    task automatic set_alarm(logic [31:0] v);
        @(negedge clk);
        alarm_wr = 1'b1;
        alarm_wdata = v;
        @(negedge clk);
        alarm_wr = 1'b0;
        m_alarm = v;
    endtask

    task automatic set_sw(int v, string req);
        @(negedge clk);
        swatch_wr = 1'b1;
        swatch_wdata = SW_W'(v);
        @(negedge clk);
        swatch_wr = 1'b0;
        m_sw = v;
        chk_all(req);
    endtask

    task automatic set_ctrl(logic [6:0] v, string req);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        m_ctrl = v;
        chk_all(req);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk_all("R1");
        chk("R1", "alarm", alarm_q, 32'h0);
        chk("R1", "ctrl", 32'(ctrl_q), 32'h0);

        set_ctrl(7'h7F, "R10");
        set_alarm(pack(65));
        // R2 R5 R7 R8: long sweep from zero, clearing after each step
        for (int i = 0; i < 3700; i++) begin
            tick_clr(7'h00, "R2");
            clr(7'h7F, "R5");
        end

        // R2 R5: across a day boundary (day 5, 23:59:50)
        set_time(pack(5 * DAY_S + DAY_S - 10), "R11");
        for (int i = 0; i < 20; i++) begin
            tick_clr(7'h00, "R5");
            clr(7'h7F, "R5");
        end

        // R3: day field wraps from 32767 to 0
        set_time(pack(WRAP_S - 2), "R11");
        for (int i = 0; i < 3; i++) tick_clr(7'h7F, "R3");
        chk("R3", "day field", 32'(time_q[31:17]), 32'h0);

        // R7: time-of-day match on a different day; R8 must stay quiet
        set_alarm(pack(9 * DAY_S + 3602));
        set_time(pack(2 * DAY_S + 3595), "R11");
        clr(7'h7F, "R7");
        for (int i = 0; i < 10; i++) tick_clr(7'h00, "R7");
        chk("R8", "full alarm quiet", 32'(status_q[6]), 32'h0);
        clr(7'h7F, "R7");
        // R8: same time of day on the alarm's own day
        set_time(pack(9 * DAY_S + 3595), "R11");
        for (int i = 0; i < 10; i++) tick_clr(7'h00, "R8");
        chk("R8", "full alarm set", 32'(status_q[6]), 32'h1);
        clr(7'h7F, "R8");

        // R9: countdown, hold at zero, silent zero, re-arm
        set_sw(5, "R9");
        for (int i = 0; i < 8; i++) tick_clr(7'h7E, "R9");
        clr(7'h7F, "R9");
        set_sw(0, "R9");
        for (int i = 0; i < 3; i++) tick_clr(7'h7E, "R9");
        set_sw(2, "R9");
        for (int i = 0; i < 3; i++) tick_clr(7'h7E, "R9");
        clr(7'h7F, "R9");

        // R4: prescaler divides by DIV when enabled
        set_time(32'h0, "R11");
        @(negedge clk);
        presc_en = 1'b1;
        m_pcnt = 0;
        for (int i = 0; i < 3 * DIV + 1; i++) tick_clr(7'h7F, "R4");
        @(negedge clk);
        presc_en = 1'b0;
        m_pcnt = 0;
        tick_clr(7'h7F, "R4");

        // R6: partial clear, zero-mask clear, clear colliding with new event
        set_time(pack(59), "R11");
        clr(7'h7F, "R6");
        tick_clr(7'h00, "R6");
        clr(7'h04, "R6");
        chk("R6", "minute kept", 32'(status_q[3]), 32'h1);
        clr(7'h00, "R6");
        tick_clr(7'h04, "R6");
        chk("R6", "set wins", 32'(status_q[2]), 32'h1);
        clr(7'h7F, "R6");

        // R10: masked flags do not reach irq
        set_ctrl(7'h08, "R10");
        tick_clr(7'h00, "R10");
        clr(7'h7F, "R10");
        set_time(pack(119), "R11");
        tick_clr(7'h00, "R10");
        chk("R10", "irq from minute", 32'(irq), 32'h1);
        clr(7'h7F, "R10");

        // R11: time write collides with a tick; write wins, no events
        @(negedge clk);
        osc_tick = 1'b1;
        time_wr = 1'b1;
        time_wdata = pack(3 * DAY_S + 7);
        @(negedge clk);
        osc_tick = 1'b0;
        time_wr = 1'b0;
        m_tot = 3 * DAY_S + 7;
        model_advance(1'b1);
        chk_all("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule